// File: doc/BRIEF.md
# Stereo/Dual Identification Sequencer

This block drives a one-bit mode select that alternates between a stereo identification setting and a dual identification setting. The dwell time in each setting comes from a period value that software writes. An upstream tone filter, tuned by that select, returns a single detect bit. While the detect bit stays low the select keeps alternating. When the detect bit goes high the alternation stops and the select holds the mode it is in.

The raw detect bit is not reported directly. It feeds a saturating up/down counter that acts as a digital integrator. A comparator with hysteresis follows the counter and produces one qualified flag. That flag is published as a stereo flag or a dual flag, whichever matches the held mode, for a status read-out.

When the qualified flag drops, the hold is released and alternation resumes after one full period. A short burst of detect that never qualifies also releases the hold once the counter has drained back to zero.

Top module: `ident_mode_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mode_sel_o` is 0 (stereo) and both `stereo_flag_o` and `dual_flag_o` are 0. The encoding is 0 for stereo and 1 for dual.
- R2: With the detect bit low and no hold in force, `mode_sel_o` stays in each mode for exactly P clock cycles, where P is `period_i`. A value of 0 is treated as P = 1. The first change after reset happens on the P-th clock edge.
- R3: Any clock edge at which `tone_det_i` is high never changes `mode_sel_o`. While the detect bit stays high, the select holds its mode indefinitely.
- R4: The integrator count rises by one on each edge with the detect bit high and falls by one on each edge with it low. It saturates at `int_max_i` and at 0. A low detect bit starting from count 0 never produces a flag.
- R5: The qualified flag becomes 1 on the edge after the count reaches at least `thr_hi_i`. It becomes 0 on the edge after the count is at or below `thr_lo_i`. A count of k is reached after k consecutive detect-high edges that start from 0.
- R6: `stereo_flag_o` can be 1 only while the held mode is stereo (0), and `dual_flag_o` only while it is dual (1). While either flag is 1, `mode_sel_o` does not change.
- R7: On the edge where the qualified flag clears, the hold is released. A detect burst that never qualifies releases the hold on the edge after the count returns to 0. After a release, the next mode change comes exactly P edges later.
- R8: Every mode change resets the integrator count to 0 and clears the qualified flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_det_i | input | 1 | Raw detect bit from the tone filter |
| period_i | input | PER_W | Dwell time in each mode, in clock cycles (0 acts as 1) |
| int_max_i | input | CNT_W | Saturation ceiling of the integrator |
| thr_hi_i | input | CNT_W | Count at which the flag sets |
| thr_lo_i | input | CNT_W | Count at or below which the flag clears |
| mode_sel_o | output | 1 | Current identification mode, 0 stereo, 1 dual |
| stereo_flag_o | output | 1 | Qualified detection while held in stereo |
| dual_flag_o | output | 1 | Qualified detection while held in dual |

## Verification
Alternation is measured with an idle detect input at several period values, including 1 and 0. This separates the correct dwell length from an off-by-one or a missing zero guard. A long detect run that overshoots the ceiling and is then removed pins down three things: the set edge, the saturation level (it sets how late the flag clears) and the one-period resume. A three-cycle glitch shows rejection and the drain-to-zero release. A wide hysteresis band paired with a two-cycle period shows whether the integrator is cleared on a mode change, because a leftover count would make the next dual flag set early.

// File: rtl/ident_pkg.sv
package ident_pkg;

  typedef enum logic {
    MODE_STEREO = 1'b0,
    MODE_DUAL   = 1'b1
  } ident_mode_e;

  localparam int unsigned NUM_MODES = 2;

  function automatic ident_mode_e other_mode(input ident_mode_e m);
    return (m == MODE_STEREO) ? MODE_DUAL : MODE_STEREO;
  endfunction

endpackage

// File: rtl/ident_rate_timer.sv
module ident_rate_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  output logic             wrap_o
);

  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  // last tick index of a dwell; a zero period behaves as one cycle
  function automatic logic [PER_W-1:0] last_tick(input logic [PER_W-1:0] p);
    return (p == '0) ? '0 : p - ONE;
  endfunction

  logic [PER_W-1:0] tick_q;
  logic [PER_W-1:0] last_w;

  assign last_w = last_tick(period_i);
  assign wrap_o = run_i && (tick_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (!run_i || wrap_o) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_q + ONE;
    end
  end

  a_r2_wrap_restarts : assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (tick_q == '0));

  a_r7_idle_parks : assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (tick_q == '0));

endmodule

// File: rtl/ident_integrator.sv
module ident_integrator #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // one saturating up/down step
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic             up,
                                            input logic [CNT_W-1:0] ceil);
    if (up) begin
      return (c >= ceil) ? ceil : c + ONE;
    end
    return (c == '0) ? '0 : c - ONE;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= step(cnt_q, det_i, max_i);
    end
  end

  assign cnt_o = cnt_q;

  a_r4_ceiling : assert property (@(posedge clk) disable iff (!rst_n)
    (det_i && !clr_i && cnt_q == max_i) |=> (cnt_q == $past(max_i)));

  a_r4_floor : assert property (@(posedge clk) disable iff (!rst_n)
    (!det_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0));

  a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/ident_hyst_cmp.sv
module ident_hyst_cmp #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  input  logic [CNT_W-1:0] thr_lo_i,
  input  logic             clr_i,
  output logic             qual_o,
  output logic             fall_o
);

  // clear has priority, so a flag can only set on a count above the low mark
  function automatic logic decide(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] hi,
                                  input logic [CNT_W-1:0] lo,
                                  input logic             cur);
    if (c <= lo) return 1'b0;
    if (c >= hi) return 1'b1;
    return cur;
  endfunction

  logic qual_q;
  logic qual_d;

  assign qual_d = clr_i ? 1'b0 : decide(cnt_i, thr_hi_i, thr_lo_i, qual_q);
  assign fall_o = qual_q && !qual_d;
  assign qual_o = qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
    end else begin
      qual_q <= qual_d;
    end
  end

  a_r5_rise_above_hi : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual_q) |-> ($past(cnt_i) >= $past(thr_hi_i)));

  a_r5_fall_at_lo : assert property (@(posedge clk) disable iff (!rst_n)
    (qual_q && !clr_i && cnt_i <= thr_lo_i) |=> !qual_q);

endmodule

// File: rtl/ident_mode_sequencer.sv
module ident_mode_sequencer #(
  parameter int unsigned PER_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_det_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [CNT_W-1:0] int_max_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  input  logic [CNT_W-1:0] thr_lo_i,
  output logic             mode_sel_o,
  output logic             stereo_flag_o,
  output logic             dual_flag_o
);

  import ident_pkg::*;

  // named internal events
  logic             hold_q;
  logic             run_w;
  logic             wrap_w;
  logic             qual_w;
  logic             qual_fall_w;
  logic             release_w;
  logic [CNT_W-1:0] cnt_w;
  ident_mode_e      mode_q;
  logic [NUM_MODES-1:0] flag_w;

  assign run_w     = !hold_q && !tone_det_i;
  assign release_w = hold_q && !tone_det_i &&
                     (qual_fall_w || (!qual_w && cnt_w == '0));

  ident_rate_timer #(.PER_W(PER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_w),
    .period_i (period_i),
    .wrap_o   (wrap_w)
  );

  ident_integrator #(.CNT_W(CNT_W)) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .det_i (tone_det_i),
    .clr_i (wrap_w),
    .max_i (int_max_i),
    .cnt_o (cnt_w)
  );

  ident_hyst_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_i    (cnt_w),
    .thr_hi_i (thr_hi_i),
    .thr_lo_i (thr_lo_i),
    .clr_i    (wrap_w),
    .qual_o   (qual_w),
    .fall_o   (qual_fall_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (tone_det_i) begin
      hold_q <= 1'b1;
    end else if (release_w) begin
      hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STEREO;
    end else if (wrap_w) begin
      mode_q <= other_mode(mode_q);
    end
  end

  // one status flag per mode, raised only for the held mode
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_flag
    assign flag_w[m] = qual_w && (mode_q == ident_mode_e'(m));
  end

  assign mode_sel_o    = mode_q;
  assign stereo_flag_o = flag_w[MODE_STEREO];
  assign dual_flag_o   = flag_w[MODE_DUAL];

  a_r3_detect_freezes : assert property (@(posedge clk) disable iff (!rst_n)
    tone_det_i |=> $stable(mode_sel_o));

  a_r6_flag_holds_mode : assert property (@(posedge clk) disable iff (!rst_n)
    (stereo_flag_o || dual_flag_o) |=> $stable(mode_sel_o));

  a_r6_single_flag : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stereo_flag_o, dual_flag_o}));

  a_r7_release_when_clear : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !qual_w);

endmodule

// File: tb/ident_mode_sequencer_bench.sv
module ident_mode_sequencer_bench;

  localparam int unsigned PER_W = 16;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tone_det_i;
  logic [PER_W-1:0] period_i;
  logic [CNT_W-1:0] int_max_i;
  logic [CNT_W-1:0] thr_hi_i;
  logic [CNT_W-1:0] thr_lo_i;
  logic             mode_sel_o;
  logic             stereo_flag_o;
  logic             dual_flag_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ident_mode_sequencer #(.PER_W(PER_W), .CNT_W(CNT_W)) u_ident_mode_sequencer (
    .clk           (clk),
    .rst_n         (rst_n),
    .tone_det_i    (tone_det_i),
    .period_i      (period_i),
    .int_max_i     (int_max_i),
    .thr_hi_i      (thr_hi_i),
    .thr_lo_i      (thr_lo_i),
    .mode_sel_o    (mode_sel_o),
    .stereo_flag_o (stereo_flag_o),
    .dual_flag_o   (dual_flag_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // advance n rising edges, return positioned at a falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int per, input int mx, input int hi, input int lo);
    @(negedge clk);
    rst_n      = 1'b0;
    tone_det_i = 1'b0;
    period_i   = PER_W'(per);
    int_max_i  = CNT_W'(mx);
    thr_hi_i   = CNT_W'(hi);
    thr_lo_i   = CNT_W'(lo);
    edges(2);
    chk_eq("R1 mode in reset", mode_sel_o, 0);
    chk_eq("R1 flags in reset", {stereo_flag_o, dual_flag_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(5, 15, 8, 3);
    edges(1);
    chk_eq("R1 mode after reset", mode_sel_o, 0);
    chk_eq("R1 stereo flag after reset", stereo_flag_o, 0);
    chk_eq("R1 dual flag after reset", dual_flag_o, 0);
  endtask

  task automatic t_period(input int per);
    int p;
    p = (per == 0) ? 1 : per;
    do_reset(per, 15, 8, 3);
    if (p > 1) begin
      edges(p - 1);
      chk_eq("R2 before first change", mode_sel_o, 0);
      edges(1);
    end else begin
      edges(1);
    end
    chk_eq("R2 first change", mode_sel_o, 1);
    if (p > 1) begin
      edges(p - 1);
      chk_eq("R2 dual dwell", mode_sel_o, 1);
      edges(1);
    end else begin
      edges(1);
    end
    chk_eq("R2 second change", mode_sel_o, 0);
  endtask

  task automatic t_floor;
    bit seen;
    do_reset(100, 15, 8, 3);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      edges(1);
      if (stereo_flag_o || dual_flag_o) seen = 1'b1;
    end
    chk_eq("R4 no flag from idle count at zero", seen, 0);
  endtask

  task automatic t_dual_freeze;
    do_reset(3, 15, 8, 3);
    edges(3);
    chk_eq("R2 dual after one period", mode_sel_o, 1);
    tone_det_i = 1'b1;
    edges(8);
    chk_eq("R5 no dual flag below threshold", dual_flag_o, 0);
    chk_eq("R3 held in dual", mode_sel_o, 1);
    edges(1);
    chk_eq("R6 dual flag set", dual_flag_o, 1);
    chk_eq("R6 stereo flag stays clear", stereo_flag_o, 0);
    edges(20);
    chk_eq("R3 still held in dual", mode_sel_o, 1);
    tone_det_i = 1'b0;
  endtask

  task automatic t_saturate_resume;
    do_reset(5, 15, 8, 3);
    tone_det_i = 1'b1;
    edges(8);
    chk_eq("R5 stereo flag before threshold", stereo_flag_o, 0);
    edges(1);
    chk_eq("R5 stereo flag set", stereo_flag_o, 1);
    chk_eq("R6 dual flag clear in stereo", dual_flag_o, 0);
    edges(21);
    chk_eq("R3 held in stereo", mode_sel_o, 0);
    tone_det_i = 1'b0;
    edges(12);
    chk_eq("R4 flag kept while draining from ceiling", stereo_flag_o, 1);
    edges(1);
    chk_eq("R5 flag cleared at low mark", stereo_flag_o, 0);
    edges(4);
    chk_eq("R7 no change before a full period", mode_sel_o, 0);
    edges(1);
    chk_eq("R7 change one period after release", mode_sel_o, 1);
  endtask

  task automatic t_glitch;
    bit seen;
    do_reset(4, 15, 8, 3);
    edges(1);
    tone_det_i = 1'b1;
    edges(3);
    tone_det_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 7; i++) begin
      if (stereo_flag_o || dual_flag_o) seen = 1'b1;
      chk_eq("R7 held during drain", mode_sel_o, 0);
      edges(1);
    end
    chk_eq("R5 glitch rejected", seen, 0);
    chk_eq("R7 held until period after drain", mode_sel_o, 0);
    edges(1);
    chk_eq("R7 resumes after drain", mode_sel_o, 1);
  endtask

  task automatic t_clear_on_change;
    int guard;
    do_reset(2, 15, 8, 6);
    tone_det_i = 1'b1;
    edges(10);
    chk_eq("R5 flag set in wide band", stereo_flag_o, 1);
    tone_det_i = 1'b0;
    edges(5);
    chk_eq("R5 flag cleared at wide low mark", stereo_flag_o, 0);
    chk_eq("R7 mode still stereo", mode_sel_o, 0);
    edges(2);
    chk_eq("R7 change two edges after release", mode_sel_o, 1);
    tone_det_i = 1'b1;
    edges(8);
    chk_eq("R8 count restarted on mode change", dual_flag_o, 0);
    edges(1);
    chk_eq("R8 dual flag after full climb", dual_flag_o, 1);
    tone_det_i = 1'b0;
    guard = 0;
  endtask

  initial begin
    rst_n      = 1'b0;
    tone_det_i = 1'b0;
    period_i   = '0;
    int_max_i  = '0;
    thr_hi_i   = '0;
    thr_lo_i   = '0;
    t_reset_state();
    t_period(4);
    t_period(7);
    t_period(1);
    t_period(0);
    t_floor();
    t_dual_freeze();
    t_saturate_resume();
    t_glitch();
    t_clear_on_change();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule